// File: doc/BRIEF.md
# Self-Repairing Logic Cell Array

The block holds a row of configurable logic cells. Each cell reads four single-bit inputs and drives one output bit. A 66-bit configuration code selects the logic function. The inputs of a cell pass through input registers that are kept in three copies and majority-voted. An upset in one copy therefore never reaches the function unit. Each function unit is evaluated twice, by two differently built paths, and the two results are compared on every cycle. A disagreement that lasts two consecutive cycles is taken to be a permanent fault in that unit.

Every working cell has a dormant spare of its own. When the working cell is declared faulty, a per-cell healing controller retires it in a fixed order, one clock per step:
1. Turn the output off.
2. Connect the four inputs to the spare.
3. Copy the spare's stored configuration code into its function register.

After these steps the spare drives the output. The spare is then watched in the same way. If the spare also fails, the output is pinned to 0 and an unrecoverable flag is raised for a supervisor above the array. Fault-injection inputs let a test upset a register copy or break a function unit.

Each healing controller has six states:
- `ST_ACTIVE`: the working cell drives the output.
- `ST_KILL`: the output is off.
- `ST_ROUTE`: the inputs are steered to the spare.
- `ST_LOAD`: the spare runs on its loaded code, and the output is still off.
- `ST_SPARE`: the spare drives the output.
- `ST_DEAD`: the output is forced to 0.

The transitions are:
- detect: `ST_ACTIVE` to `ST_KILL` on a trip of the working cell.
- three unconditional steps: `ST_KILL` to `ST_ROUTE`, `ST_ROUTE` to `ST_LOAD`, and `ST_LOAD` to `ST_SPARE`.
- give up: `ST_SPARE` to `ST_DEAD` on a trip of the spare.

`ST_DEAD` is terminal.

Top module: `cell_heal_array`

## Requirements
- R1: While reset is asserted, and right after it, every `cell_out`, `healing`, `act_fault`, `spare_fault` and `unrecov` bit is 0, and all stored configuration codes are 0.
- R2: A configuration code is 66 bits. Bits [63:0] form four 16-entry truth tables, and bits [65:64] pick one of them. A working cell outputs bit `code[{code[65:64], in}]`, where `in` is its nibble `cell_in[4c+3:4c]`. The output appears after the second rising edge following an input change.
- R3: A one-cycle upset of any single register copy (`seu_copy` 0, 1 or 2), with any bit mask, leaves `cell_out` unchanged. All copies are reloaded on the next edge.
- R4: A function-unit disagreement lasting a single cycle sets no fault, and the output keeps its last value. A disagreement on two consecutive edges sets the sticky `act_fault` on the second edge.
- R5: On that second edge healing starts. `healing` stays high for exactly three cycles (kill, reroute, load), and `cell_out` is 0 throughout.
- R6: When `healing` falls, the cell output follows the spare's stored code, evaluated with the R2 rule on the same inputs. Code writes made after the reroute step, to either memory of that cell, have no effect on the output.
- R7: A spare is watched only while it drives the output. Two consecutive disagreements there set `spare_fault` and `unrecov`, and `cell_out` is 0 from then on. A fault injected into an idle spare sets nothing.
- R8: Faults, healing and upsets in one cell leave the outputs and flags of every other cell unchanged.
- R9: A write with `cfg_we` high stores `cfg_data` into the working-cell memory (`cfg_spare`=0) or the spare memory (`cfg_spare`=1) of cell `cfg_cell`, at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_in | input | NUM_CELLS*NUM_IN | Input nibble of each cell |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_cell | input | CELL_W | Cell addressed by the write |
| cfg_spare | input | 1 | 1 writes the spare memory, 0 the working memory |
| cfg_data | input | CFG_W | Configuration code to store |
| seu_en | input | NUM_CELLS | Per-cell upset injection into input registers |
| seu_copy | input | 2 | Register copy that receives the upset |
| seu_mask | input | NUM_IN | Bits flipped by the upset |
| perm_act | input | NUM_CELLS | Breaks the working function unit of a cell |
| perm_spare | input | NUM_CELLS | Breaks the spare function unit of a cell |
| cell_out | output | NUM_CELLS | Cell outputs |
| healing | output | NUM_CELLS | Healing sequence in progress |
| act_fault | output | NUM_CELLS | Sticky permanent fault of the working cell |
| spare_fault | output | NUM_CELLS | Sticky permanent fault of the spare |
| unrecov | output | NUM_CELLS | Both units failed; output forced to 0 |

## Verification
The outputs have these delays:
- **Data:** a data result is due at the falling edge after the second rising edge following an input change. A voted upset is checked in the same way.
- **Fault flag and healing:** the fault flag and `healing` are due after the second edge of a sustained injection. They are also checked after the first edge, to confirm they are still low and the output has been held.
- **Spare takes over:** the spare output is due after the fifth edge.
- **Unrecoverable:** `unrecov` is due after the second edge of a sustained spare injection.

The bench steps one edge at a time through these windows and samples on the falling edge. It compares against a bench model that tracks which unit drives each cell. It also samples the untouched cells at every step.

// File: rtl/cha_pkg.sv
package cha_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_KILL   = 3'd1,
        ST_ROUTE  = 3'd2,
        ST_LOAD   = 3'd3,
        ST_SPARE  = 3'd4,
        ST_DEAD   = 3'd5
    } heal_state_e;

    localparam int TMR_COPIES = 3;

endpackage

// File: rtl/tmr_in_reg.sv
module tmr_in_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    input  logic         upset_en,
    input  logic [1:0]   upset_copy,
    input  logic [W-1:0] upset_mask,
    output logic [W-1:0] q
);
    import cha_pkg::*;

    logic [TMR_COPIES-1:0][W-1:0] cp;

    // every edge rewrites all copies, which scrubs any disagreement
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cp <= '0;
        end else begin
            for (int k = 0; k < TMR_COPIES; k++) begin
                cp[k] <= d ^ ((upset_en && (upset_copy == 2'(k))) ? upset_mask : '0);
            end
        end
    end

    assign q = (cp[0] & cp[1]) | (cp[0] & cp[2]) | (cp[1] & cp[2]);

endmodule

// File: rtl/fn_unit_sc.sv
module fn_unit_sc #(
    parameter int TBL_W   = 64,
    parameter int PERSIST = 2,
    localparam int IDX_W  = $clog2(TBL_W),
    localparam int CNT_W  = $clog2(PERSIST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TBL_W-1:0] tbl,
    input  logic [IDX_W-1:0] idx,
    input  logic             break_en,
    input  logic             monitor,
    output logic             res,
    output logic             mismatch,
    output logic             trip,
    output logic             fault_flag
);
    logic             shadow;
    logic [CNT_W-1:0] run_cnt;

    // primary path: direct bit select (fault injection flips it)
    assign res = tbl[idx] ^ break_en;

    // shadow path: one-hot mask and reduction, built differently
    assign shadow   = |(tbl & (TBL_W'(1) << idx));
    assign mismatch = res ^ shadow;
    assign trip     = monitor && mismatch && (run_cnt == CNT_W'(PERSIST - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!monitor || !mismatch) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_W'(PERSIST - 1)) begin
            run_cnt <= run_cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_flag <= 1'b0;
        end else if (trip) begin
            fault_flag <= 1'b1;
        end
    end

endmodule

// File: rtl/heal_fsm.sv
module heal_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic act_trip,
    input  logic spare_trip,
    output logic healing,
    output logic route_en,
    output logic code_load,
    output logic out_gate,
    output logic act_mon,
    output logic spare_mon,
    output logic use_spare,
    output logic dead
);
    import cha_pkg::*;

    heal_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: if (act_trip)   state_d = ST_KILL;
            ST_KILL:                   state_d = ST_ROUTE;
            ST_ROUTE:                  state_d = ST_LOAD;
            ST_LOAD:                   state_d = ST_SPARE;
            ST_SPARE:  if (spare_trip) state_d = ST_DEAD;
            ST_DEAD:                   state_d = ST_DEAD;
            default:                   state_d = ST_DEAD;
        endcase
    end

    always_comb begin
        healing   = 1'b0;
        route_en  = 1'b0;
        code_load = 1'b0;
        out_gate  = 1'b0;
        act_mon   = 1'b0;
        spare_mon = 1'b0;
        use_spare = 1'b0;
        dead      = 1'b0;
        unique case (state_q)
            ST_ACTIVE: begin
                out_gate = 1'b1;
                act_mon  = 1'b1;
            end
            ST_KILL: begin
                healing = 1'b1;
            end
            ST_ROUTE: begin
                healing   = 1'b1;
                route_en  = 1'b1;
                code_load = 1'b1;
            end
            ST_LOAD: begin
                healing   = 1'b1;
                route_en  = 1'b1;
                use_spare = 1'b1;
            end
            ST_SPARE: begin
                route_en  = 1'b1;
                use_spare = 1'b1;
                out_gate  = 1'b1;
                spare_mon = 1'b1;
            end
            ST_DEAD: begin
                dead = 1'b1;
            end
            default: begin
                dead = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/cell_pair.sv
module cell_pair #(
    parameter int NUM_IN     = 4,
    parameter int PAGE_SEL_W = 2,
    parameter int PERSIST    = 2,
    localparam int LUT_W     = 2 ** NUM_IN,
    localparam int TBL_W     = LUT_W * (2 ** PAGE_SEL_W),
    localparam int CFG_W     = TBL_W + PAGE_SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_IN-1:0] din,
    input  logic              we_act,
    input  logic              we_spare,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              seu_en,
    input  logic [1:0]        seu_copy,
    input  logic [NUM_IN-1:0] seu_mask,
    input  logic              perm_act,
    input  logic              perm_spare,
    output logic              dout,
    output logic              healing,
    output logic              act_fault,
    output logic              spare_fault,
    output logic              unrecov
);
    logic [CFG_W-1:0]  act_mem, spare_mem, spare_code_q;
    logic [NUM_IN-1:0] act_in, spare_in, spare_d;
    logic act_res, act_mis, act_trip;
    logic spare_res, spare_mis, spare_trip;
    logic route_en, code_load, out_gate, act_mon, spare_mon, use_spare;
    logic out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_mem      <= '0;
            spare_mem    <= '0;
            spare_code_q <= '0;
        end else begin
            if (we_act)    act_mem   <= wdata;
            if (we_spare)  spare_mem <= wdata;
            if (code_load) spare_code_q <= spare_mem;
        end
    end

    assign spare_d = route_en ? din : '0;

    tmr_in_reg #(.W(NUM_IN)) u_act_in (
        .clk(clk), .rst_n(rst_n), .d(din),
        .upset_en(seu_en), .upset_copy(seu_copy), .upset_mask(seu_mask),
        .q(act_in)
    );

    tmr_in_reg #(.W(NUM_IN)) u_spare_in (
        .clk(clk), .rst_n(rst_n), .d(spare_d),
        .upset_en(seu_en), .upset_copy(seu_copy), .upset_mask(seu_mask),
        .q(spare_in)
    );

    fn_unit_sc #(.TBL_W(TBL_W), .PERSIST(PERSIST)) u_act_fn (
        .clk(clk), .rst_n(rst_n),
        .tbl(act_mem[TBL_W-1:0]),
        .idx({act_mem[CFG_W-1:TBL_W], act_in}),
        .break_en(perm_act), .monitor(act_mon),
        .res(act_res), .mismatch(act_mis), .trip(act_trip),
        .fault_flag(act_fault)
    );

    fn_unit_sc #(.TBL_W(TBL_W), .PERSIST(PERSIST)) u_spare_fn (
        .clk(clk), .rst_n(rst_n),
        .tbl(spare_code_q[TBL_W-1:0]),
        .idx({spare_code_q[CFG_W-1:TBL_W], spare_in}),
        .break_en(perm_spare), .monitor(spare_mon),
        .res(spare_res), .mismatch(spare_mis), .trip(spare_trip),
        .fault_flag(spare_fault)
    );

    heal_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .act_trip(act_trip), .spare_trip(spare_trip),
        .healing(healing), .route_en(route_en), .code_load(code_load),
        .out_gate(out_gate), .act_mon(act_mon), .spare_mon(spare_mon),
        .use_spare(use_spare), .dead(unrecov)
    );

    // output register keeps its value whenever the selected unit disagrees
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (use_spare) begin
            if (!spare_mis) out_q <= spare_res;
        end else if (act_mon) begin
            if (!act_mis) out_q <= act_res;
        end
    end

    assign dout = out_q & out_gate;

endmodule

// File: rtl/cell_heal_array.sv
module cell_heal_array #(
    parameter int NUM_CELLS  = 4,
    parameter int NUM_IN     = 4,
    parameter int PAGE_SEL_W = 2,
    parameter int PERSIST    = 2,
    localparam int CELL_W    = $clog2(NUM_CELLS),
    localparam int CFG_W     = (2 ** NUM_IN) * (2 ** PAGE_SEL_W) + PAGE_SEL_W
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_CELLS*NUM_IN-1:0] cell_in,
    input  logic                        cfg_we,
    input  logic [CELL_W-1:0]           cfg_cell,
    input  logic                        cfg_spare,
    input  logic [CFG_W-1:0]            cfg_data,
    input  logic [NUM_CELLS-1:0]        seu_en,
    input  logic [1:0]                  seu_copy,
    input  logic [NUM_IN-1:0]           seu_mask,
    input  logic [NUM_CELLS-1:0]        perm_act,
    input  logic [NUM_CELLS-1:0]        perm_spare,
    output logic [NUM_CELLS-1:0]        cell_out,
    output logic [NUM_CELLS-1:0]        healing,
    output logic [NUM_CELLS-1:0]        act_fault,
    output logic [NUM_CELLS-1:0]        spare_fault,
    output logic [NUM_CELLS-1:0]        unrecov
);
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_cell
        logic hit;
        assign hit = cfg_we && (cfg_cell == CELL_W'(c));

        cell_pair #(
            .NUM_IN(NUM_IN), .PAGE_SEL_W(PAGE_SEL_W), .PERSIST(PERSIST)
        ) u_pair (
            .clk(clk), .rst_n(rst_n),
            .din(cell_in[c*NUM_IN +: NUM_IN]),
            .we_act(hit && !cfg_spare), .we_spare(hit && cfg_spare),
            .wdata(cfg_data),
            .seu_en(seu_en[c]), .seu_copy(seu_copy), .seu_mask(seu_mask),
            .perm_act(perm_act[c]), .perm_spare(perm_spare[c]),
            .dout(cell_out[c]), .healing(healing[c]),
            .act_fault(act_fault[c]), .spare_fault(spare_fault[c]),
            .unrecov(unrecov[c])
        );
    end

endmodule

// File: rtl/cell_heal_array_chk.sv
module cell_heal_array_chk #(
    parameter int NUM_CELLS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_CELLS-1:0] perm_act,
    input logic [NUM_CELLS-1:0] cell_out,
    input logic [NUM_CELLS-1:0] healing,
    input logic [NUM_CELLS-1:0] act_fault,
    input logic [NUM_CELLS-1:0] spare_fault,
    input logic [NUM_CELLS-1:0] unrecov
);
    for (genvar c = 0; c < NUM_CELLS; c++) begin : g_chk
        // R5: healing lasts exactly three cycles
        a_r5_three_steps: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(healing[c]) |=> healing[c] ##1 healing[c] ##1 !healing[c]);
        // R5: output silent while healing
        a_r5_quiet_heal: assert property (@(posedge clk) disable iff (!rst_n)
            healing[c] |-> !cell_out[c]);
        // R4: fault flag is sticky
        a_r4_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            act_fault[c] |=> act_fault[c]);
        // R4: flag rises together with healing, after two faulty cycles
        a_r4_flag_starts_heal: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(act_fault[c]) |-> $rose(healing[c]) && $past(perm_act[c]) && $past(perm_act[c], 2));
        // R7: dead cell stays silent and flagged
        a_r7_dead_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            unrecov[c] |-> !cell_out[c] && !healing[c]);
        a_r7_dead_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            unrecov[c] |=> unrecov[c]);
        a_r7_dead_both_failed: assert property (@(posedge clk) disable iff (!rst_n)
            unrecov[c] |-> act_fault[c] && spare_fault[c]);
    end
endmodule

bind cell_heal_array cell_heal_array_chk #(.NUM_CELLS(NUM_CELLS)) chk_i (
    .clk(clk), .rst_n(rst_n), .perm_act(perm_act), .cell_out(cell_out),
    .healing(healing), .act_fault(act_fault), .spare_fault(spare_fault),
    .unrecov(unrecov)
);

// File: tb/cell_heal_array_tb_top.sv
module cell_heal_array_tb_top;
    localparam int NC = 4;
    localparam int NI = 4;
    localparam int CW = 66;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NC*NI-1:0] cell_in = '0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_cell = '0;
    logic cfg_spare = 1'b0;
    logic [CW-1:0] cfg_data = '0;
    logic [NC-1:0] seu_en = '0;
    logic [1:0] seu_copy = '0;
    logic [NI-1:0] seu_mask = '0;
    logic [NC-1:0] perm_act = '0;
    logic [NC-1:0] perm_spare = '0;
    logic [NC-1:0] cell_out, healing, act_fault, spare_fault, unrecov;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;

    logic [CW-1:0] act_cfg [NC];
    logic [CW-1:0] spr_cfg [NC];
    logic [CW-1:0] spr_live [NC];
    int mode [NC];  // 0 working cell, 1 spare, 2 dead

    always #10 clk = ~clk;  // 50 MHz

    cell_heal_array dut_i (
        .clk(clk), .rst_n(rst_n), .cell_in(cell_in), .cfg_we(cfg_we),
        .cfg_cell(cfg_cell), .cfg_spare(cfg_spare), .cfg_data(cfg_data),
        .seu_en(seu_en), .seu_copy(seu_copy), .seu_mask(seu_mask),
        .perm_act(perm_act), .perm_spare(perm_spare), .cell_out(cell_out),
        .healing(healing), .act_fault(act_fault), .spare_fault(spare_fault),
        .unrecov(unrecov)
    );

    function automatic logic f_eval(input logic [CW-1:0] code, input logic [NI-1:0] x);
        return code[{code[CW-1:CW-2], x}];
    endfunction

    function automatic logic f_exp(input int c);
        logic [NI-1:0] x = cell_in[c*NI +: NI];
        if (mode[c] == 0) return f_eval(act_cfg[c], x);
        if (mode[c] == 1) return f_eval(spr_live[c], x);
        return 1'b0;
    endfunction

    function automatic logic [CW-1:0] rnd_code();
        logic [95:0] t = {$urandom(), $urandom(), $urandom()};
        return t[CW-1:0];
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_cells(input string req, input int skip);
        for (int c = 0; c < NC; c++) begin
            if (c != skip) chk($sformatf("%s cell%0d out", req, c), cell_out[c], f_exp(c));
        end
    endtask

    task automatic wr_cfg(input int c, input bit spare, input logic [CW-1:0] v);
        cfg_we = 1'b1;
        cfg_cell = 2'(c);
        cfg_spare = spare;
        cfg_data = v;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic apply(input logic [NC*NI-1:0] v);
        cell_in = v;
        tick();
        tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog (all requirements): actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_c311));
        for (int c = 0; c < NC; c++) mode[c] = 0;

        // R1 reset state
        @(negedge clk);
        tick();
        for (int c = 0; c < NC; c++) begin
            chk("R1 out", cell_out[c], 1'b0);
            chk("R1 healing", healing[c], 1'b0);
            chk("R1 act_fault", act_fault[c], 1'b0);
            chk("R1 spare_fault", spare_fault[c], 1'b0);
            chk("R1 unrecov", unrecov[c], 1'b0);
        end
        rst_n = 1'b1;
        cell_in = 16'hFFFF;
        tick();
        tick();
        for (int c = 0; c < NC; c++) chk("R1 zero code after reset", cell_out[c], 1'b0);

        // R9 configuration writes
        for (int c = 0; c < NC; c++) begin
            act_cfg[c] = rnd_code();
            spr_cfg[c] = rnd_code();
            wr_cfg(c, 1'b0, act_cfg[c]);
            wr_cfg(c, 1'b1, spr_cfg[c]);
        end
        tick();
        check_cells("R9", -1);

        // R2 random patterns and all page selections
        for (int n = 0; n < 40; n++) begin
            if (n % 10 == 0) begin
                int c = $urandom_range(0, NC - 1);
                act_cfg[c] = rnd_code();
                wr_cfg(c, 1'b0, act_cfg[c]);
            end
            apply(16'($urandom()));
            check_cells("R2", -1);
        end
        for (int p = 0; p < 4; p++) begin
            act_cfg[2][CW-1:CW-2] = 2'(p);
            wr_cfg(2, 1'b0, act_cfg[2]);
            for (int x = 0; x < 16; x++) begin
                apply({cell_in[15:12], 4'(x), cell_in[7:0]});
                chk($sformatf("R2 page%0d idx%0d", p, x), cell_out[2], f_exp(2));
            end
        end

        // R3 single-copy upsets
        for (int n = 0; n < 24; n++) begin
            cell_in = 16'($urandom());
            tick();
            tick();
            seu_en = 4'($urandom());
            seu_copy = 2'(n % 3);
            seu_mask = 4'($urandom_range(1, 15));
            tick();
            seu_en = '0;
            check_cells("R3 upset edge", -1);
            tick();
            check_cells("R3 after upset", -1);
        end

        // R4 single-cycle disagreement on cell1
        apply(16'h5A3C);
        perm_act[1] = 1'b1;
        tick();
        perm_act[1] = 1'b0;
        chk("R4 held during glitch", cell_out[1], f_exp(1));
        tick();
        chk("R4 glitch sets no fault", act_fault[1], 1'b0);
        chk("R4 glitch no healing", healing[1], 1'b0);
        chk("R4 out after glitch", cell_out[1], f_exp(1));

        // R7 idle spare fault is ignored
        perm_spare[3] = 1'b1;
        tick();
        tick();
        tick();
        chk("R7 idle spare no flag", spare_fault[3], 1'b0);
        chk("R7 idle spare no unrecov", unrecov[3], 1'b0);
        chk("R7 idle spare out", cell_out[3], f_exp(3));
        perm_spare[3] = 1'b0;

        // R4/R5/R6/R8 permanent fault and healing of cell0
        apply(16'h9E61);
        perm_act[0] = 1'b1;
        tick();
        chk("R4 one edge no flag", act_fault[0], 1'b0);
        chk("R4 one edge out held", cell_out[0], f_exp(0));
        check_cells("R8", 0);
        tick();
        chk("R4 flag on second edge", act_fault[0], 1'b1);
        for (int s = 0; s < 3; s++) begin
            chk($sformatf("R5 healing step%0d", s), healing[0], 1'b1);
            chk($sformatf("R5 out off step%0d", s), cell_out[0], 1'b0);
            check_cells("R8", 0);
            if (s == 1) begin
                act_cfg[0] = rnd_code();
                spr_live[0] = spr_cfg[0];
                cfg_we = 1'b1;
                cfg_cell = 2'd0;
                cfg_spare = 1'b1;
                cfg_data = rnd_code();
                tick();
                cfg_we = 1'b0;
            end else begin
                tick();
            end
        end
        mode[0] = 1;
        chk("R5 healing ends", healing[0], 1'b0);
        chk("R6 spare drives output", cell_out[0], f_exp(0));
        wr_cfg(0, 1'b0, act_cfg[0]);
        for (int n = 0; n < 20; n++) begin
            apply(16'($urandom()));
            check_cells("R6", -1);
        end

        // R7 spare failure on cell0
        perm_spare[0] = 1'b1;
        tick();
        chk("R7 one edge no unrecov", unrecov[0], 1'b0);
        chk("R7 one edge out held", cell_out[0], f_exp(0));
        tick();
        mode[0] = 2;
        chk("R7 unrecov raised", unrecov[0], 1'b1);
        chk("R7 spare flag", spare_fault[0], 1'b1);
        chk("R7 out forced low", cell_out[0], 1'b0);
        for (int n = 0; n < 8; n++) begin
            apply(16'($urandom()));
            check_cells("R7/R8", -1);
        end
        for (int c = 1; c < NC; c++) begin
            chk("R8 other flags", act_fault[c] | spare_fault[c] | unrecov[c] | healing[c], 1'b0);
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule